// File: doc/BRIEF.md
# I2C Repeated-Start Generator with Collision Detection

This block produces the repeated-start condition of an I2C master on open-drain SCL and SDA wires, and watches the wires for a second master contending for the bus. A one-cycle request starts a fixed sequence with three timed phases. A down-counter is reloaded from a 7-bit value for each phase and steps once per baud tick. First the block lets SDA float high while it still holds SCL low. It then lets SCL go, waits until SCL is seen high, and samples SDA. It drives SDA low while SCL stays high, and at the end it pulls SCL low again.

The sampled wire levels first pass through a two-flop synchronizer, and edges are taken from the synchronized values. There are two kinds of collision. In the first, SDA reads low at the moment SCL is first seen high, which means another master is sending a 0. In the second, SCL falls while SDA is still released, which means another master is sending a 1. A collision releases both wires, ends the sequence without a completion pulse and sets a collision flag. The flag stays set until it is cleared explicitly. A second output tells which kind of collision happened.

Top module: `i2c_rstart_gen`

## Requirements
- R1: After reset both drive enables are 0 (wires released), `busy`, `done` and `collision` are 0.
- R2: A request while idle raises `busy` on the next edge, releases SDA, holds SCL low and loads the counter with `reload`. With `reload` = N the first phase lasts exactly N+1 baud ticks, and then SCL is released. N = 0 gives one tick.
- R3: The counter moves only on cycles where `baud_tick` is 1. Cycles without a tick do not shorten any phase.
- R4: After SCL is released, the block waits for a low-to-high edge on the synchronized SCL. If the synchronized SDA is low at that edge, it flags a collision with `coll_kind` = 0 (another master sending a 0).
- R5: If SDA is high at that edge, the counter is reloaded and a second phase of N+1 ticks begins. A falling edge on the synchronized SCL during this phase, while SDA is not driven, is a collision with `coll_kind` = 1 (another master sending a 1).
- R6: A high-to-low change of SDA during the second phase is not a collision. When the second phase expires with SCL high, SDA is driven low and a third phase of N+1 ticks begins.
- R7: When the third phase expires, SCL is driven low whatever its level. `done` pulses high for exactly one cycle, `busy` falls, and both drive enables stay 1.
- R8: A collision drops both drive enables to 0, returns the block to idle (`busy` = 0) and produces no `done` pulse.
- R9: `collision` stays 1 until `coll_clr` is asserted, including across later completed sequences. A new collision in the same cycle as a clear wins.
- R10: A request while `busy` is 1 is ignored. The running sequence keeps its timing and gives a single `done`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | One-cycle request to start a repeated start |
| reload | input | 7 | Counter reload value N; each phase lasts N+1 ticks |
| baud_tick | input | 1 | Counter step enable |
| scl_in | input | 1 | Sampled SCL wire level |
| sda_in | input | 1 | Sampled SDA wire level |
| coll_clr | input | 1 | Clears the collision flag |
| scl_drive_low | output | 1 | 1 pulls SCL low, 0 releases it |
| sda_drive_low | output | 1 | 1 pulls SDA low, 0 releases it |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle pulse on completion |
| collision | output | 1 | Sticky collision flag |
| coll_kind | output | 1 | Kind of the last collision: 0 = rival sent 0, 1 = rival sent 1 |

## Verification
The assertions check rules that hold on every cycle. `done` lasts one cycle and leaves both wires driven low. Any drop of `busy` without `done` leaves both wires released and the flag set. SDA is only pulled low after SCL has been released. `busy` only starts from a request, and the flag is never lost without a clear. The bench's scenarios are needed for the things that depend on the bus. These include the exact phase length measured in ticks, which kind of collision a contending master causes, why SDA pulled low by a rival in the second phase is tolerated, and that a request while busy leaves the timing unchanged.

// File: rtl/rs_pkg.sv
package rs_pkg;

    localparam int RELOAD_W    = 7;
    localparam int SYNC_STAGES = 2;

    // Bit positions of the two wires inside a line vector
    localparam int LINE_SDA = 0;
    localparam int LINE_SCL = 1;
    localparam int N_LINES  = 2;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RISE,     // SDA released, SCL held low, counting
        ST_SCLWAIT,  // SCL released, waiting for its rising edge
        ST_SETUP,    // both high, counting, watching SCL
        ST_HOLD      // SDA driven low, counting until SCL is pulled
    } rs_state_e;

    typedef enum logic {
        COLL_RIVAL_ZERO = 1'b0,
        COLL_RIVAL_ONE  = 1'b1
    } rs_coll_e;

    typedef struct packed {
        logic scl_low;
        logic sda_low;
    } rs_drive_t;

    function automatic logic phase_expired(input logic tick, input logic [RELOAD_W-1:0] cnt);
        return tick && (cnt == '0);
    endfunction

endpackage

// File: rtl/rs_line_sync.sv
module rs_line_sync #(
    parameter int STAGES = rs_pkg::SYNC_STAGES,
    parameter int LINES  = rs_pkg::N_LINES,
    parameter int EDGE_LINE = rs_pkg::LINE_SCL
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [LINES-1:0] raw,
    output logic [LINES-1:0] level,
    output logic             edge_rose,
    output logic             edge_fell
);
    localparam int LAST = STAGES - 1;

    for (genvar g = 0; g < LINES; g++) begin : g_line
        logic [STAGES-1:0] chain;
        always_ff @(posedge clk) begin
            if (rst) chain <= '1;
            else     chain <= {chain[STAGES-2:0], raw[g]};
        end
        assign level[g] = chain[LAST];
    end

    logic prev_q;
    always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b1;
        else     prev_q <= level[EDGE_LINE];
    end

    assign edge_rose = ~prev_q & level[EDGE_LINE];
    assign edge_fell = prev_q & ~level[EDGE_LINE];
endmodule

// File: rtl/rs_baud_cnt.sv
module rs_baud_cnt #(
    parameter int W = rs_pkg::RELOAD_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         tick,
    output logic         expire
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)                       cnt_q <= '0;
        else if (load)                 cnt_q <= load_val;
        else if (tick && cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
    end

    assign expire = rs_pkg::phase_expired(tick, cnt_q);
endmodule

// File: rtl/rs_seq_fsm.sv
module rs_seq_fsm
    import rs_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      req,
    input  logic      expire,
    input  logic      scl_s,
    input  logic      sda_s,
    input  logic      scl_rose,
    input  logic      scl_fell,
    input  logic      coll_clr,
    output logic      load,
    output rs_drive_t drv,
    output logic      busy,
    output logic      done,
    output logic      coll,
    output rs_coll_e  kind
);
    rs_state_e state_q, state_n;
    rs_drive_t drv_q, drv_n;
    rs_coll_e  kind_q, kind_n;
    logic      done_q, done_n;
    logic      coll_q, coll_evt;

    always_comb begin
        state_n  = state_q;
        drv_n    = drv_q;
        kind_n   = kind_q;
        done_n   = 1'b0;
        coll_evt = 1'b0;
        load     = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (req) begin
                    state_n       = ST_RISE;
                    drv_n.sda_low = 1'b0;
                    drv_n.scl_low = 1'b1;
                    load          = 1'b1;
                end
            end
            ST_RISE: begin
                if (expire) begin
                    drv_n.scl_low = 1'b0;
                    state_n       = ST_SCLWAIT;
                end
            end
            ST_SCLWAIT: begin
                if (scl_rose) begin
                    if (!sda_s) begin
                        coll_evt = 1'b1;
                        kind_n   = COLL_RIVAL_ZERO;
                    end else begin
                        load    = 1'b1;
                        state_n = ST_SETUP;
                    end
                end
            end
            ST_SETUP: begin
                if (scl_fell && !drv_q.sda_low) begin
                    coll_evt = 1'b1;
                    kind_n   = COLL_RIVAL_ONE;
                end else if (expire) begin
                    if (!scl_s) begin
                        coll_evt = 1'b1;
                        kind_n   = COLL_RIVAL_ONE;
                    end else begin
                        drv_n.sda_low = 1'b1;
                        load          = 1'b1;
                        state_n       = ST_HOLD;
                    end
                end
            end
            ST_HOLD: begin
                if (expire) begin
                    drv_n.scl_low = 1'b1;
                    done_n        = 1'b1;
                    state_n       = ST_IDLE;
                end
            end
            default: state_n = ST_IDLE;
        endcase
        if (coll_evt) begin
            drv_n   = '0;
            state_n = ST_IDLE;
            load    = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            drv_q   <= '0;
            kind_q  <= COLL_RIVAL_ZERO;
            done_q  <= 1'b0;
            coll_q  <= 1'b0;
        end else begin
            state_q <= state_n;
            drv_q   <= drv_n;
            kind_q  <= kind_n;
            done_q  <= done_n;
            if (coll_evt)      coll_q <= 1'b1;
            else if (coll_clr) coll_q <= 1'b0;
        end
    end

    assign drv  = drv_q;
    assign busy = (state_q != ST_IDLE);
    assign done = done_q;
    assign coll = coll_q;
    assign kind = kind_q;
endmodule

// File: rtl/i2c_rstart_gen.sv
module i2c_rstart_gen
    import rs_pkg::*;
#(
    parameter int RW = RELOAD_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          req,
    input  logic [RW-1:0] reload,
    input  logic          baud_tick,
    input  logic          scl_in,
    input  logic          sda_in,
    input  logic          coll_clr,
    output logic          scl_drive_low,
    output logic          sda_drive_low,
    output logic          busy,
    output logic          done,
    output logic          collision,
    output logic          coll_kind
);
    logic [N_LINES-1:0] raw_lines, sync_lines;
    logic               scl_rose, scl_fell;
    logic               cnt_load, cnt_expire;
    rs_drive_t          drv;
    rs_coll_e           kind;

    always_comb begin
        raw_lines           = '0;
        raw_lines[LINE_SCL] = scl_in;
        raw_lines[LINE_SDA] = sda_in;
    end

    rs_line_sync #(
        .STAGES    (SYNC_STAGES),
        .LINES     (N_LINES),
        .EDGE_LINE (LINE_SCL)
    ) u_sync (
        .clk       (clk),
        .rst       (rst),
        .raw       (raw_lines),
        .level     (sync_lines),
        .edge_rose (scl_rose),
        .edge_fell (scl_fell)
    );

    rs_baud_cnt #(.W(RW)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .load     (cnt_load),
        .load_val (reload),
        .tick     (baud_tick),
        .expire   (cnt_expire)
    );

    rs_seq_fsm u_fsm (
        .clk      (clk),
        .rst      (rst),
        .req      (req),
        .expire   (cnt_expire),
        .scl_s    (sync_lines[LINE_SCL]),
        .sda_s    (sync_lines[LINE_SDA]),
        .scl_rose (scl_rose),
        .scl_fell (scl_fell),
        .coll_clr (coll_clr),
        .load     (cnt_load),
        .drv      (drv),
        .busy     (busy),
        .done     (done),
        .coll     (collision),
        .kind     (kind)
    );

    assign scl_drive_low = drv.scl_low;
    assign sda_drive_low = drv.sda_low;
    assign coll_kind     = kind;
endmodule

// File: rtl/i2c_rstart_gen_chk.sv
module i2c_rstart_gen_chk (
    input logic clk,
    input logic rst,
    input logic req,
    input logic coll_clr,
    input logic scl_drive_low,
    input logic sda_drive_low,
    input logic busy,
    input logic done,
    input logic collision
);
    a_r7_done_single: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    a_r7_done_drives: assert property (@(posedge clk) disable iff (rst)
        done |-> (scl_drive_low && sda_drive_low && !busy));

    a_r8_abort_release: assert property (@(posedge clk) disable iff (rst)
        ($fell(busy) && !done) |-> (!scl_drive_low && !sda_drive_low && collision));

    a_r9_sticky: assert property (@(posedge clk) disable iff (rst)
        (collision && !coll_clr) |=> collision);

    a_r6_sda_after_scl: assert property (@(posedge clk) disable iff (rst)
        $rose(sda_drive_low) |-> (!scl_drive_low && busy));

    a_r10_start_by_req: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(req));

    a_r2_start_drive: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> (scl_drive_low && !sda_drive_low));
endmodule

bind i2c_rstart_gen i2c_rstart_gen_chk u_chk (
    .clk           (clk),
    .rst           (rst),
    .req           (req),
    .coll_clr      (coll_clr),
    .scl_drive_low (scl_drive_low),
    .sda_drive_low (sda_drive_low),
    .busy          (busy),
    .done          (done),
    .collision     (collision)
);

// File: tb/sim_i2c_rstart_gen.sv
`timescale 1ns/1ps
module sim_i2c_rstart_gen;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       req = 1'b0;
    logic [6:0] reload = '0;
    logic       tick_auto = 1'b0;
    logic       tick_man = 1'b0;
    logic       coll_clr = 1'b0;
    logic       rv_scl = 1'b0;
    logic       rv_sda = 1'b0;
    logic       scl_drive_low, sda_drive_low, busy, done, collision, coll_kind;
    logic       baud_tick, scl_line, sda_line;
    int         checks = 0;
    int         failures = 0;
    bit         finished = 1'b0;

    always #2.5 clk = ~clk;

    assign baud_tick = tick_auto | tick_man;
    assign scl_line  = ~(scl_drive_low | rv_scl);
    assign sda_line  = ~(sda_drive_low | rv_sda);

    i2c_rstart_gen u0 (
        .clk(clk), .rst(rst), .req(req), .reload(reload), .baud_tick(baud_tick),
        .scl_in(scl_line), .sda_in(sda_line), .coll_clr(coll_clr),
        .scl_drive_low(scl_drive_low), .sda_drive_low(sda_drive_low),
        .busy(busy), .done(done), .collision(collision), .coll_kind(coll_kind)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic pulse_req(input int n);
        @(negedge clk);
        reload = 7'(n);
        req = 1'b1;
        @(negedge clk);
        req = 1'b0;
    endtask

    // Runs until idle; counts cycles and done pulses, notes SCL level when SDA gets driven
    task automatic run_out(output int cyc, output int dones, output int scl_at_sda);
        bit prev_sda;
        cyc = 1; dones = 0; scl_at_sda = -1;
        prev_sda = sda_drive_low;
        while (busy && cyc < 2000) begin
            @(negedge clk);
            cyc++;
            if (done) dones++;
            if (sda_drive_low && !prev_sda) scl_at_sda = int'(scl_drive_low);
            prev_sda = sda_drive_low;
        end
    endtask

    task automatic wait_scl_release(input int limit);
        for (int i = 0; i < limit && scl_drive_low; i++) @(negedge clk);
    endtask

    task automatic t_reset;
        chk(!scl_drive_low && !sda_drive_low, "R1 drives", {scl_drive_low, sda_drive_low}, 0);
        chk(!busy && !done && !collision, "R1 flags", {busy, done, collision}, 0);
    endtask

    task automatic t_tick_count(input int n);
        tick_auto = 1'b0;
        pulse_req(n);
        chk(busy && scl_drive_low && !sda_drive_low, "R2 start drive",
            {busy, scl_drive_low, sda_drive_low}, 3'b110);
        for (int i = 0; i < n; i++) begin
            tick_man = 1'b1; @(negedge clk); tick_man = 1'b0;
            repeat (2) @(negedge clk);
        end
        chk(scl_drive_low, "R3 SCL held after N ticks", scl_drive_low, 1);
        tick_man = 1'b1; @(negedge clk); tick_man = 1'b0;
        chk(!scl_drive_low, "R2 SCL released after N+1 ticks", scl_drive_low, 0);
        tick_auto = 1'b1;
        begin
            int c, d, s;
            run_out(c, d, s);
            chk(d == 1, "R7 one done", d, 1);
            chk(scl_drive_low && sda_drive_low && !busy, "R7 final drives",
                {scl_drive_low, sda_drive_low, busy}, 3'b110);
            chk(s == 0, "R6 SDA driven with SCL released", s, 0);
            chk(!collision, "R6 no collision", collision, 0);
        end
    endtask

    task automatic t_rival_zero;
        rv_sda = 1'b1; tick_auto = 1'b1;
        pulse_req(2);
        begin
            int c, d, s;
            run_out(c, d, s);
            chk(d == 0, "R8 no done on collision", d, 0);
            chk(collision && coll_kind == 1'b0, "R4 rival zero", {collision, coll_kind}, 2'b10);
            chk(!scl_drive_low && !sda_drive_low, "R8 released", {scl_drive_low, sda_drive_low}, 0);
        end
        rv_sda = 1'b0;
        repeat (10) @(negedge clk);
        chk(collision, "R9 sticky idle", collision, 1);
    endtask

    task automatic t_clear;
        @(negedge clk); coll_clr = 1'b1; @(negedge clk); coll_clr = 1'b0;
        chk(!collision, "R9 cleared", collision, 0);
    endtask

    task automatic t_rival_one;
        tick_auto = 1'b1;
        pulse_req(10);
        wait_scl_release(100);
        repeat (5) @(negedge clk);
        rv_scl = 1'b1;
        begin
            int c, d, s;
            run_out(c, d, s);
            chk(d == 0, "R8 no done rival one", d, 0);
            chk(collision && coll_kind == 1'b1, "R5 rival one", {collision, coll_kind}, 2'b11);
            chk(!scl_drive_low && !sda_drive_low, "R8 released rival one",
                {scl_drive_low, sda_drive_low}, 0);
        end
        rv_scl = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic t_sda_fall_ok;
        tick_auto = 1'b1;
        pulse_req(10);
        wait_scl_release(100);
        repeat (5) @(negedge clk);
        rv_sda = 1'b1;
        begin
            int c, d, s;
            run_out(c, d, s);
            chk(d == 1, "R6 done despite SDA fall", d, 1);
            chk(!collision, "R6 no collision on SDA fall", collision, 0);
        end
        rv_sda = 1'b0;
    endtask

    task automatic t_busy_ignore;
        int c1, c2, d, s;
        tick_auto = 1'b1;
        pulse_req(4);
        run_out(c1, d, s);
        pulse_req(4);
        repeat (3) @(negedge clk);
        req = 1'b1; reload = 7'd20; @(negedge clk); req = 1'b0; reload = 7'd4;
        run_out(c2, d, s);
        c2 += 4;
        chk(c1 == c2, "R10 timing unchanged", c2, c1);
        chk(d == 1, "R10 single done", d, 1);
    endtask

    task automatic t_sticky_across;
        int c, d, s;
        rv_sda = 1'b1; pulse_req(1); run_out(c, d, s); rv_sda = 1'b0;
        pulse_req(1); run_out(c, d, s);
        chk(d == 1 && collision, "R9 flag kept across good run", collision, 1);
        t_clear();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_tick_count(3);
        t_tick_count(0);
        t_rival_zero();
        t_clear();
        t_rival_one();
        t_clear();
        t_sda_fall_ok();
        t_busy_ignore();
        t_sticky_across();
        finished = 1'b1;
    end

    initial begin
        for (int i = 0; i < 100000 && !finished; i++) @(posedge clk);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule